// File: doc/BRIEF.md
# Serial EEPROM Write Master with Acknowledge Polling

This block is a two-wire bus master that stores one byte in a serial EEPROM. It then finds out when the memory has finished its internal programming cycle. A single-cycle command pulse supplies a word address and a data byte. The master sends a start condition, the write control byte, the address, the data and a stop. Right after that stop it begins polling. Each poll is a start followed by the write control byte. A target that is still programming leaves the ninth clock unacknowledged, and the master tries again with a repeated start. When the target answers, the master closes the bus with a stop and pulses `done`.

The number of polls is bounded by `MAX_POLLS`. If every poll goes unanswered, the master releases the bus with a stop and raises a sticky `timeout` flag. The next accepted command clears that flag.

Both bus lines are open-drain. The block only ever pulls a line low or lets it go, through one enable output per line. Bit timing is built from a clock divider. Each bit takes four quarter periods of `QTR_DIV` clocks.

Top module: `ackpoll_writer`

## Requirements
- R1: After reset, and whenever `busy` is low, `scl_oe` and `sda_oe` are both 0 (lines released), and `done` and `timeout` are 0 after reset.
- R2: A command sends, in order: a start, the control byte 0xA0, the address byte, the data byte, and a stop. The control byte is 1010, then three zero select bits, then R/W = 0 as the last bit. Bytes go out most significant bit first.
- R3: Polling starts right after the write stop, with a start followed by the control byte 0xA0.
- R4: A poll whose ninth-clock sample finds SDA high (no acknowledge) is followed by a repeated start and the control byte 0xA0 again, with no stop in between.
- R5: A poll whose ninth-clock sample finds SDA low is followed by a stop. `done` then goes high for exactly one clock, with `busy` low in that same clock.
- R6: If `MAX_POLLS` polls all go unacknowledged, the master issues a stop, sets `timeout`, returns to idle and never pulses `done`. `timeout` stays set until the next accepted command clears it.
- R7: A `cmd_valid` pulse while `busy` is high is ignored: the running transfer keeps its address and data, and no further transfer follows.
- R8: Each SCL high phase lasts exactly 2·`QTR_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Starts a write when idle |
| cmd_addr | input | 8 | Word address to write |
| cmd_data | input | 8 | Data byte to write |
| sda_in | input | 1 | Level seen on the SDA line |
| busy | output | 1 | Transfer or polling in progress |
| done | output | 1 | One-clock pulse: write confirmed complete |
| timeout | output | 1 | Sticky: poll limit reached without an acknowledge |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check several things on every cycle. Both lines are released whenever the master is idle, and `done` is a lone pulse that comes with `busy` low and `timeout` clear. A timeout can only rise together with the return to idle, and an accepted command always makes the block busy.

Other behaviour can only be shown by the bench's scenarios, using a target model that decodes the bus. That covers the exact byte order on the wire and the number of starts and stops. It also covers the boundary between success on the last allowed poll and a timeout, rejection of a command that arrives mid-transfer, and the measured SCL high time.

// File: rtl/ackpoll_pkg.sv
// Shared types and constants for the acknowledge-polling write master.
// Assumes 8-bit bus bytes and a write-only control byte with select bits tied to zero.
package ackpoll_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam logic [2:0] DEV_SEL  = 3'b000;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2
    } op_kind_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_W_START,
        SQ_W_CTRL,
        SQ_W_ADDR,
        SQ_W_DATA,
        SQ_W_STOP,
        SQ_P_START,
        SQ_P_CTRL,
        SQ_P_STOP,
        SQ_F_STOP
    } seq_state_t;

    // Builds the control byte from device type, select bits and the R/W flag.
    function automatic logic [BYTE_W-1:0] ctrl_byte(input logic rw);
        return {DEV_TYPE, DEV_SEL, rw};
    endfunction
endpackage

// File: rtl/ackpoll_tick_gen.sv
// Quarter-bit tick generator: while enabled, pulses tick once every QTR_DIV clocks.
// Assumes QTR_DIV >= 2. The count restarts from zero each time enable drops.
module ackpoll_tick_gen #(
    parameter int QTR_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Counts clocks within a quarter period and wraps on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/ackpoll_bit_engine.sv
// Bus primitive engine: runs one START, BYTE (8 bits out plus ack sample) or STOP.
// Each bit takes four ticks. SCL is pulled low at quarter 0 and 3 and released at quarter 1.
// Assumes SCL is low at the start of a BYTE, and low or released before a START.
// The ack is sampled at quarter 2 of the ninth bit through a two-stage synchronizer.
module ackpoll_bit_engine
    import ackpoll_pkg::*;
#(
    parameter int QTR_DIV = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  op_kind_t          op_kind,
    input  logic [BYTE_W-1:0] op_byte,
    output logic              op_done,
    output logic              op_ack,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] ACK_BIT = BCW'(BYTE_W);

    logic              busy_q;
    op_kind_t          kind_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BCW-1:0]    bitcnt_q;
    logic [1:0]        qtr_q;
    logic              scl_oe_q, sda_oe_q, ack_q, done_q;
    logic [1:0]        sda_sync_q;
    logic              tick;

    ackpoll_tick_gen #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy_q),
        .tick (tick)
    );

    // Brings the external SDA level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_sync_q <= 2'b11;
        else        sda_sync_q <= {sda_sync_q[0], sda_in};
    end

    // Accepts one primitive and steps it through its quarter phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            kind_q   <= OP_STOP;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            qtr_q    <= 2'd0;
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            ack_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (op_valid) begin
                    busy_q   <= 1'b1;
                    kind_q   <= op_kind;
                    shreg_q  <= op_byte;
                    bitcnt_q <= '0;
                    qtr_q    <= 2'd0;
                end
            end else if (tick) begin
                qtr_q <= qtr_q + 2'd1;
                unique case (kind_q)
                    OP_START: begin
                        unique case (qtr_q)
                            2'd0: sda_oe_q <= 1'b0;
                            2'd1: scl_oe_q <= 1'b0;
                            2'd2: sda_oe_q <= 1'b1;
                            default: begin
                                scl_oe_q <= 1'b1;
                                busy_q   <= 1'b0;
                                done_q   <= 1'b1;
                            end
                        endcase
                    end
                    OP_BYTE: begin
                        unique case (qtr_q)
                            2'd0: begin
                                scl_oe_q <= 1'b1;
                                sda_oe_q <= (bitcnt_q == ACK_BIT) ? 1'b0 : ~shreg_q[BYTE_W-1];
                            end
                            2'd1: scl_oe_q <= 1'b0;
                            2'd2: if (bitcnt_q == ACK_BIT) ack_q <= ~sda_sync_q[1];
                            default: begin
                                scl_oe_q <= 1'b1;
                                if (bitcnt_q == ACK_BIT) begin
                                    busy_q <= 1'b0;
                                    done_q <= 1'b1;
                                end else begin
                                    bitcnt_q <= bitcnt_q + 1'b1;
                                    shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                                end
                            end
                        endcase
                    end
                    default: begin
                        unique case (qtr_q)
                            2'd0: begin
                                scl_oe_q <= 1'b1;
                                sda_oe_q <= 1'b1;
                            end
                            2'd1: scl_oe_q <= 1'b0;
                            2'd2: sda_oe_q <= 1'b0;
                            default: begin
                                busy_q <= 1'b0;
                                done_q <= 1'b1;
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    assign op_done = done_q;
    assign op_ack  = ack_q;
    assign scl_oe  = scl_oe_q;
    assign sda_oe  = sda_oe_q;
endmodule

// File: rtl/ackpoll_sequencer.sv
// Transaction sequencer: orders the write frame and the polling loop, counts polls,
// and reports done or timeout. Assumes op_done arrives only for a primitive it launched.
module ackpoll_sequencer
    import ackpoll_pkg::*;
#(
    parameter int MAX_POLLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              op_valid,
    output op_kind_t          op_kind,
    output logic [BYTE_W-1:0] op_byte,
    input  logic              op_done,
    input  logic              op_ack,
    output logic              busy,
    output logic              done,
    output logic              timeout
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

    seq_state_t        state_q;
    logic              launched_q;
    logic [BYTE_W-1:0] addr_q, data_q;
    logic [PW-1:0]     polls_q;
    logic              done_q, timeout_q;

    assign busy     = (state_q != SQ_IDLE);
    assign op_valid = busy && !launched_q;

    // Selects the primitive and byte for the current state.
    always_comb begin
        op_kind = OP_BYTE;
        op_byte = ctrl_byte(1'b0);
        unique case (state_q)
            SQ_W_START, SQ_P_START:           op_kind = OP_START;
            SQ_W_STOP, SQ_P_STOP, SQ_F_STOP:  op_kind = OP_STOP;
            SQ_W_ADDR:                        op_byte = addr_q;
            SQ_W_DATA:                        op_byte = data_q;
            default: ;
        endcase
    end

    // Advances through the frame and polling loop on each completed primitive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            launched_q <= 1'b0;
            addr_q     <= '0;
            data_q     <= '0;
            polls_q    <= '0;
            done_q     <= 1'b0;
            timeout_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == SQ_IDLE) begin
                if (cmd_valid) begin
                    addr_q     <= cmd_addr;
                    data_q     <= cmd_data;
                    timeout_q  <= 1'b0;
                    launched_q <= 1'b0;
                    state_q    <= SQ_W_START;
                end
            end else if (op_valid) begin
                launched_q <= 1'b1;
            end else if (op_done) begin
                launched_q <= 1'b0;
                unique case (state_q)
                    SQ_W_START: state_q <= SQ_W_CTRL;
                    SQ_W_CTRL:  state_q <= SQ_W_ADDR;
                    SQ_W_ADDR:  state_q <= SQ_W_DATA;
                    SQ_W_DATA:  state_q <= SQ_W_STOP;
                    SQ_W_STOP: begin
                        polls_q <= '0;
                        state_q <= SQ_P_START;
                    end
                    SQ_P_START: state_q <= SQ_P_CTRL;
                    SQ_P_CTRL: begin
                        if (op_ack) begin
                            state_q <= SQ_P_STOP;
                        end else if (polls_q == LAST_POLL) begin
                            state_q <= SQ_F_STOP;
                        end else begin
                            polls_q <= polls_q + 1'b1;
                            state_q <= SQ_P_START;
                        end
                    end
                    SQ_P_STOP: begin
                        done_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end
                    default: begin
                        timeout_q <= 1'b1;
                        state_q   <= SQ_IDLE;
                    end
                endcase
            end
        end
    end

    assign done    = done_q;
    assign timeout = timeout_q;
endmodule

// File: rtl/ackpoll_writer.sv
// Top level: write one byte to a serial EEPROM, then poll with write control bytes
// until the target acknowledges or MAX_POLLS polls fail. Outputs are open-drain enables.
// Assumes a single master and no clock stretching by the target.
module ackpoll_writer
    import ackpoll_pkg::*;
#(
    parameter int QTR_DIV   = 125,
    parameter int MAX_POLLS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_addr,
    input  logic [7:0] cmd_data,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output logic       timeout,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic              op_valid, op_done, op_ack;
    op_kind_t          op_kind;
    logic [BYTE_W-1:0] op_byte;

    ackpoll_sequencer #(.MAX_POLLS(MAX_POLLS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_byte  (op_byte),
        .op_done  (op_done),
        .op_ack   (op_ack),
        .busy     (busy),
        .done     (done),
        .timeout  (timeout)
    );

    ackpoll_bit_engine #(.QTR_DIV(QTR_DIV)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_valid(op_valid),
        .op_kind (op_kind),
        .op_byte (op_byte),
        .op_done (op_done),
        .op_ack  (op_ack),
        .sda_in  (sda_in),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );
endmodule

// File: rtl/ackpoll_writer_chk.sv
// Protocol checker for ackpoll_writer, attached by bind. Observes top-level ports only.
module ackpoll_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic scl_oe,
    input logic sda_oe
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
    AST_DONE_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !timeout); // R6
    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> !busy); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy); // R7
endmodule

bind ackpoll_writer ackpoll_writer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
);

// File: tb/sim_ackpoll_writer.sv
`timescale 1ns/1ps
module sim_ackpoll_writer;
    localparam int QD = 4;
    localparam int MP = 4;
    localparam int NV = 6;
    // {addr, data, number of polls the target leaves unacknowledged}
    localparam logic [23:0] VEC [0:NV-1] = '{
        {8'h3C, 8'h5A, 8'd0},
        {8'hFF, 8'h00, 8'd1},
        {8'h00, 8'hFF, 8'd3},
        {8'h81, 8'h7E, 8'd4},
        {8'h47, 8'hC3, 8'd6},
        {8'hA5, 8'h96, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_addr = 8'h00, cmd_data = 8'h00;
    logic busy, done, timeout, scl_oe, sda_oe;
    logic tgt_pull = 1'b0;
    wire scl = ~scl_oe;
    wire sda = ~(sda_oe | tgt_pull);

    always #2.5 clk = ~clk;

    ackpoll_writer #(.QTR_DIV(QD), .MAX_POLLS(MP)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .sda_in(sda), .busy(busy), .done(done),
        .timeout(timeout), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // Target model: decodes starts, stops and bytes; refuses a set number of polls.
    logic log_clr = 1'b0;
    int busy_cfg = 0;
    logic [7:0] log_b [64];
    int nb = 0, nstart = 0, nstop = 0, frame = 0, busy_left = 0, hi_cnt = 0, last_hi = 0;
    int bitn = 0;
    logic ackph = 1'b0;
    logic [7:0] sh = 8'h00;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    always @(posedge clk) begin
        if (log_clr) begin
            nb = 0; nstart = 0; nstop = 0; frame = 0; bitn = 0; ackph = 1'b0;
            busy_left = busy_cfg;
            tgt_pull <= 1'b0;
        end else begin
            if (prev_scl && scl && prev_sda && !sda) begin
                nstart++; frame++; bitn = 0; ackph = 1'b0;
            end else if (prev_scl && scl && !prev_sda && sda) begin
                nstop++;
            end
            if (!prev_scl && scl) begin
                hi_cnt = 1;
                if (bitn < 8) begin sh = {sh[6:0], sda}; bitn++; end
            end else if (prev_scl && scl) begin
                hi_cnt++;
            end
            if (prev_scl && !scl) begin
                last_hi = hi_cnt;
                if (bitn == 8 && !ackph) begin
                    if (nb < 64) log_b[nb] = sh;
                    nb++;
                    ackph = 1'b1;
                    if (frame > 1 && busy_left > 0) begin
                        busy_left--;
                        tgt_pull <= 1'b0;
                    end else begin
                        tgt_pull <= 1'b1;
                    end
                end else if (ackph) begin
                    tgt_pull <= 1'b0;
                    ackph = 1'b0;
                    bitn = 0;
                end
            end
        end
        prev_scl <= scl;
        prev_sda <= sda;
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [7:0] a, input logic [7:0] d, input int bz,
                           output logic saw_done, output logic saw_to);
        int cyc;
        @(negedge clk); busy_cfg = bz; log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        cyc = 0;
        while (!done && !timeout && cyc < 20000) begin
            @(negedge clk); cyc++;
        end
        saw_done = done;
        saw_to = timeout;
    endtask

    // Compares the decoded bus traffic with the expected frame and poll sequence.
    task automatic check_frames(input logic [7:0] a, input logic [7:0] d, input int npolls);
        chk(nb == 3 + npolls, "R2/R3 byte count", nb, 3 + npolls);
        chk(log_b[0] == 8'hA0, "R2 control byte", log_b[0], 8'hA0);
        chk(log_b[1] == a, "R2 address byte", log_b[1], a);
        chk(log_b[2] == d, "R2 data byte", log_b[2], d);
        for (int k = 0; k < npolls && k < 60; k++)
            chk(log_b[3 + k] == 8'hA0, "R3/R4 poll control byte", log_b[3 + k], 8'hA0);
        chk(nstart == 1 + npolls, "R4 start count (repeated starts)", nstart, 1 + npolls);
        chk(nstop == 2, "R5/R6 stop count", nstop, 2);
        chk(last_hi == 2 * QD, "R8 SCL high time", last_hi, 2 * QD);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
        $finish;
    end

    initial begin
        logic sd, st;
        int bz, np;
        logic [7:0] a, d;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!scl_oe && !sda_oe, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
        chk(!busy && !done && !timeout, "R1 status low in reset", {busy, done, timeout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe && !busy, "R1 idle after reset", {scl_oe, sda_oe, busy}, 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            a = VEC[i][23:16]; d = VEC[i][15:8]; bz = int'(VEC[i][7:0]);
            np = (bz >= MP) ? MP : bz + 1;
            run_cmd(a, d, bz, sd, st);
            if (bz >= MP) begin
                chk(st && !sd, "R6 timeout after poll limit", {sd, st}, 1);
                chk(!busy, "R6 idle on timeout", busy, 0);
            end else begin
                chk(sd && !st, "R5 done after acknowledged poll", {sd, st}, 2);
                chk(!busy, "R5 idle with done", busy, 0);
                @(negedge clk);
                chk(!done, "R5 done lasts one clock", done, 0);
            end
            check_frames(a, d, np);
            chk(!scl_oe && !sda_oe, "R1 lines released after transfer", {scl_oe, sda_oe}, 0);
        end

        // R6: timeout is sticky and is cleared by the next accepted command
        run_cmd(8'h10, 8'h20, MP, sd, st);
        repeat (20) @(negedge clk);
        chk(timeout, "R6 timeout stays set while idle", timeout, 1);
        @(negedge clk); busy_cfg = 0; log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0; cmd_addr = 8'h11; cmd_data = 8'h22; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        chk(!timeout && busy, "R6 timeout cleared on accept", {timeout, busy}, 1);
        while (busy) @(negedge clk);
        check_frames(8'h11, 8'h22, 1);

        // R7: a command arriving mid-transfer is ignored
        @(negedge clk); busy_cfg = 1; log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0; cmd_addr = 8'h6E; cmd_data = 8'h9B; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (60) @(negedge clk);
        cmd_addr = 8'h01; cmd_data = 8'h02; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; cmd_addr = 8'h00; cmd_data = 8'h00;
        while (busy) @(negedge clk);
        repeat (300) @(negedge clk);
        chk(!busy, "R7 no second transfer started", busy, 0);
        check_frames(8'h6E, 8'h9B, 2);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule